// File: doc/BRIEF.md
# Page-Mode Pseudo-SRAM Controller

This block sits between a clocked host and an asynchronous 16-bit pseudo-SRAM. The host hands over one request at a time through a valid/ready port: a word address, a read or write flag, two byte-lane enables, a burst length of one to four words and, for writes, all burst words packed into one wide field. The controller turns the request into a timed sequence on the memory's active-low select, output-enable, write-enable and byte-lane pins. Each interval is a count of clock cycles. The counts are derived by rounding nanosecond figures up for the chosen clock period.

The memory is organised in pages of four words. The two low address bits pick the word inside a page. The first beat of a burst is a full-length random cycle. Later beats in the same page use a short page cycle after a one-gap precharge. A burst that would leave its page releases chip select and opens the next page with a full-length cycle. The controller also limits how long short cycles may run back to back. When that budget would be exceeded, it inserts a full-length beat instead.

After reset the controller keeps chip select and power-down high for a programmable wait before it accepts any request. Read words come back one per beat, in address order, each with a one-cycle strobe.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, `mem_cs_n` and `mem_pd_n` stay high and `req_ready` stays low for `PWRUP_CYC` clock edges. `req_ready` first reads high after edge `PWRUP_CYC+1`. While `req_ready` is high, chip select is high.
- R2: A read request returns `req_len+1` words in address order, each with a one-cycle `rd_valid` pulse. Beat 0's strobe follows edge `RD_LEAD+T_RC` after the accepting edge.
- R3: `req_be` bit 0 enables lane 7:0 (`mem_lb_n`) and bit 1 enables lane 15:8 (`mem_ub_n`). Lane pins go low only while chip select is low and their enable bit is set. Disabled lanes read back as zero and are left unchanged by writes.
- R4: Each later beat inside the same page (address bits 1:0 nonzero) takes `T_PREC+T_PRC` cycles for reads and `T_PREC+T_PWC` cycles for writes.
- R5: When the next beat's address bits 1:0 are zero, chip select is released for `T_PREC` cycles. The new page then starts with a full-length beat.
- R6: A write drives the data bus while chip select is low. `mem_we_n` goes low only while chip select is low. Each written word lands at its beat's address.
- R7: Page beats are allowed only while the summed length of beats since the last full-length beat, including the candidate, is at most `RUN_LIMIT`. Otherwise a full-length beat (`RD_LEAD+T_RC` read, `T_RC` write) is used.
- R8: The controller never drives the data bus while `mem_oe_n` is low.
- R9: `req_ready` returns `T_PREC` cycles after the edge that ends the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and ready for a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | First word address |
| req_be | input | 2 | Byte-lane enables, bit 0 low byte |
| req_len | input | 2 | Burst length minus one |
| req_wdata | input | 64 | Write words, beat k in bits 16k+15:16k |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | 16 | Read word, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory word address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_pd_n | output | 1 | Power-down, held high |
| mem_dq_out | output | 16 | Write data toward memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | 16 | Data from memory |

## Verification
Every result is timed from the edge that accepts a request. Read strobe k is due the cycle after the edge equal to the running sum of beat lengths: full, page, crossing (release plus full) or forced-full under the run budget. Ready returns one precharge later. The bench recomputes those sums from the timing constants and the run-budget rule. It samples on the falling edge and demands the strobe at exactly that offset and no other. Power-up readiness is checked on the precise edge on both sides of the wait.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int WORD_W    = 16;
    localparam int BURST_MAX = 4;

    typedef enum logic [2:0] {
        ST_PWR,
        ST_IDLE,
        ST_SETUP,
        ST_ACT,
        ST_REL,
        ST_DONE
    } st_e;

    // control fields carried through a request
    typedef struct packed {
        logic       wr;
        logic [1:0] be;
        logic [1:0] left;
        logic [1:0] idx;
        logic       full;
    } ctl_t;

    function automatic int ns2cyc(input int ns, input int clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic logic [WORD_W-1:0] lane_mask(input logic [WORD_W-1:0] w,
                                                    input logic [1:0] be);
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

endpackage

// File: rtl/psram_pwrup.sv
module psram_pwrup #(
    parameter int WAIT_CYC = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    localparam int W = $clog2(WAIT_CYC + 1) + 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                      cnt <= '0;
        else if (cnt != W'(WAIT_CYC)) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == W'(WAIT_CYC));

    assert_pwr_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

endmodule

// File: rtl/psram_run_guard.sv
module psram_run_guard #(
    parameter int LIMIT = 1600,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_full,
    input  logic [LEN_W-1:0] beat_len,
    input  logic [LEN_W-1:0] page_len,
    output logic             allow_page
);
    localparam int RUN_W = $clog2(LIMIT + (2 ** LEN_W) + 1) + 1;

    logic [RUN_W-1:0] run;
    logic [RUN_W:0]   cand;

    always_ff @(posedge clk) begin
        if (rst)            run <= '0;
        else if (start)     run <= start_full ? RUN_W'(beat_len) : run + RUN_W'(beat_len);
    end

    assign cand       = {1'b0, run} + (RUN_W + 1)'(page_len);
    assign allow_page = (cand <= (RUN_W + 1)'(LIMIT));

    // R7: the run of short cycles stays inside its budget
    assert_run_cap_R7: assert property (@(posedge clk) disable iff (rst)
        run <= RUN_W'(LIMIT));

endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int LEN_W   = 6,
    parameter int T_RC    = 7,
    parameter int T_PRC   = 4,
    parameter int T_PREC  = 1,
    parameter int T_WP    = 5,
    parameter int T_PWC   = 4,
    parameter int RD_LEAD = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwr_done,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [1:0]            req_be,
    input  logic [1:0]            req_len,
    input  logic [BURST_MAX*WORD_W-1:0] req_wdata,
    output logic                  rd_valid,
    output logic [WORD_W-1:0]     rd_data,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_cs_n,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic                  mem_ub_n,
    output logic                  mem_lb_n,
    output logic                  mem_pd_n,
    output logic [WORD_W-1:0]     mem_dq_out,
    output logic                  mem_dq_oe,
    input  logic [WORD_W-1:0]     mem_dq_in,
    output logic                  g_start,
    output logic                  g_start_full,
    output logic [LEN_W-1:0]      g_beat_len,
    output logic [LEN_W-1:0]      g_page_len,
    input  logic                  g_allow_page
);
    localparam int WR_S0 = (T_RC > T_WP) ? (T_RC - T_WP) : 1;

    function automatic logic [LEN_W-1:0] setup_len(input logic wr, input logic full);
        if (!full) return LEN_W'(T_PREC);
        return wr ? LEN_W'(WR_S0) : LEN_W'(RD_LEAD);
    endfunction

    function automatic logic [LEN_W-1:0] act_len(input logic wr, input logic full);
        if (full) return wr ? LEN_W'(T_WP) : LEN_W'(T_RC);
        return wr ? LEN_W'(T_PWC) : LEN_W'(T_PRC);
    endfunction

    st_e                         st, st_n;
    ctl_t                        ctl, ctl_n;
    logic [LEN_W-1:0]            cnt, cnt_n;
    logic [ADDR_W-1:0]           addr, addr_n, nxt_a;
    logic [BURST_MAX*WORD_W-1:0] wd, wd_n;
    logic                        rdv_n;
    logic [WORD_W-1:0]           rdd_n;
    logic                        wr_eff;
    logic                        act;

    assign nxt_a  = addr + 1'b1;
    assign wr_eff = (st == ST_IDLE) ? req_write : ctl.wr;

    always_comb begin
        st_n         = st;
        ctl_n        = ctl;
        cnt_n        = cnt;
        addr_n       = addr;
        wd_n         = wd;
        rdv_n        = 1'b0;
        rdd_n        = rd_data;
        g_start      = 1'b0;
        g_start_full = 1'b0;
        case (st)
            ST_PWR: if (pwr_done) st_n = ST_IDLE;
            ST_IDLE: if (req_valid) begin
                ctl_n.wr     = req_write;
                ctl_n.be     = req_be;
                ctl_n.left   = req_len;
                ctl_n.idx    = 2'd0;
                ctl_n.full   = 1'b1;
                addr_n       = req_addr;
                wd_n         = req_wdata;
                st_n         = ST_SETUP;
                cnt_n        = setup_len(req_write, 1'b1);
                g_start      = 1'b1;
                g_start_full = 1'b1;
            end
            ST_SETUP: begin
                if (cnt == LEN_W'(1)) begin
                    st_n  = ST_ACT;
                    cnt_n = act_len(ctl.wr, ctl.full);
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_ACT: begin
                if (cnt != LEN_W'(1)) begin
                    cnt_n = cnt - 1'b1;
                end else begin
                    if (!ctl.wr) begin
                        rdv_n = 1'b1;
                        rdd_n = lane_mask(mem_dq_in, ctl.be);
                    end
                    if (ctl.left == 2'd0) begin
                        st_n  = ST_DONE;
                        cnt_n = LEN_W'(T_PREC);
                    end else begin
                        addr_n     = nxt_a;
                        ctl_n.left = ctl.left - 1'b1;
                        ctl_n.idx  = ctl.idx + 1'b1;
                        ctl_n.full = 1'b1;
                        if (nxt_a[1:0] == 2'b00) begin
                            st_n  = ST_REL;
                            cnt_n = LEN_W'(T_PREC);
                        end else if (g_allow_page) begin
                            st_n       = ST_SETUP;
                            ctl_n.full = 1'b0;
                            cnt_n      = setup_len(ctl.wr, 1'b0);
                            g_start    = 1'b1;
                        end else begin
                            st_n         = ST_SETUP;
                            cnt_n        = setup_len(ctl.wr, 1'b1);
                            g_start      = 1'b1;
                            g_start_full = 1'b1;
                        end
                    end
                end
            end
            ST_REL: begin
                if (cnt == LEN_W'(1)) begin
                    st_n         = ST_SETUP;
                    cnt_n        = setup_len(ctl.wr, 1'b1);
                    g_start      = 1'b1;
                    g_start_full = 1'b1;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_DONE: begin
                if (cnt == LEN_W'(1)) st_n = ST_IDLE;
                else                  cnt_n = cnt - 1'b1;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    assign g_page_len = setup_len(ctl.wr, 1'b0) + act_len(ctl.wr, 1'b0);
    assign g_beat_len = g_start_full ? (setup_len(wr_eff, 1'b1) + act_len(wr_eff, 1'b1))
                                     : (setup_len(wr_eff, 1'b0) + act_len(wr_eff, 1'b0));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_PWR;
            ctl      <= '0;
            cnt      <= '0;
            addr     <= '0;
            wd       <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            st       <= st_n;
            ctl      <= ctl_n;
            cnt      <= cnt_n;
            addr     <= addr_n;
            wd       <= wd_n;
            rd_valid <= rdv_n;
            rd_data  <= rdd_n;
        end
    end

    assign act        = (st == ST_SETUP) || (st == ST_ACT);
    assign req_ready  = (st == ST_IDLE);
    assign mem_addr   = addr;
    assign mem_cs_n   = !act;
    assign mem_pd_n   = 1'b1;
    assign mem_oe_n   = !(act && !ctl.wr && ((st == ST_ACT) || !ctl.full));
    assign mem_we_n   = !((st == ST_ACT) && ctl.wr);
    assign mem_lb_n   = !(act && ctl.be[0]);
    assign mem_ub_n   = !(act && ctl.be[1]);
    assign mem_dq_oe  = act && ctl.wr;
    assign mem_dq_out = wd[{ctl.idx, 4'b0000} +: WORD_W];

    assert_no_contention_R8: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    assert_we_inside_cs_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_dq_oe));

    assert_rdv_after_oe_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!mem_oe_n));

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_cs_n);

    assert_lane_in_cs_R3: assert property (@(posedge clk) disable iff (rst)
        (!mem_lb_n || !mem_ub_n) |-> !mem_cs_n);

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int CLK_PS    = 10000,
    parameter int PWRUP_CYC = ns2cyc(100000, CLK_PS),
    parameter int RUN_LIMIT = ns2cyc(16000, CLK_PS),
    parameter int T_RC      = ns2cyc(70, CLK_PS),
    parameter int T_PRC     = ns2cyc(35, CLK_PS),
    parameter int T_PREC    = ns2cyc(10, CLK_PS),
    parameter int T_WP      = ns2cyc(50, CLK_PS),
    parameter int T_PWC     = ns2cyc(35, CLK_PS),
    parameter int RD_LEAD   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [1:0]        req_len,
    input  logic [63:0]       req_wdata,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic              mem_pd_n,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in
);
    localparam int LEN_W = $clog2(2 * (T_RC + T_PRC + T_PREC + T_WP + T_PWC + RD_LEAD) + 1) + 1;

    logic             pwr_done;
    logic             g_start, g_start_full, g_allow_page;
    logic [LEN_W-1:0] g_beat_len, g_page_len;

    psram_pwrup #(.WAIT_CYC(PWRUP_CYC)) u_pwrup (
        .clk (clk),
        .rst (rst),
        .done(pwr_done)
    );

    psram_run_guard #(.LIMIT(RUN_LIMIT), .LEN_W(LEN_W)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .start     (g_start),
        .start_full(g_start_full),
        .beat_len  (g_beat_len),
        .page_len  (g_page_len),
        .allow_page(g_allow_page)
    );

    psram_seq #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .T_RC   (T_RC),
        .T_PRC  (T_PRC),
        .T_PREC (T_PREC),
        .T_WP   (T_WP),
        .T_PWC  (T_PWC),
        .RD_LEAD(RD_LEAD)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .pwr_done    (pwr_done),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_be      (req_be),
        .req_len     (req_len),
        .req_wdata   (req_wdata),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .mem_addr    (mem_addr),
        .mem_cs_n    (mem_cs_n),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n),
        .mem_ub_n    (mem_ub_n),
        .mem_lb_n    (mem_lb_n),
        .mem_pd_n    (mem_pd_n),
        .mem_dq_out  (mem_dq_out),
        .mem_dq_oe   (mem_dq_oe),
        .mem_dq_in   (mem_dq_in),
        .g_start     (g_start),
        .g_start_full(g_start_full),
        .g_beat_len  (g_beat_len),
        .g_page_len  (g_page_len),
        .g_allow_page(g_allow_page)
    );

    // R1: no access can begin before the power-up wait ends
    assert_pwr_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !pwr_done |-> (mem_cs_n && mem_pd_n));

endmodule

// File: tb/tb_psram_ctrl.sv
module tb_psram_ctrl;

    localparam int AW     = 8;
    localparam int PWR    = 50;
    localparam int LIMIT  = 15;
    localparam int PREC   = 1;
    localparam int RD_FUL = 1 + 7;
    localparam int WR_FUL = 2 + 5;
    localparam int PAGE   = 1 + 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_be = 2'b11;
    logic [1:0]    req_len = 2'd0;
    logic [63:0]   req_wdata = '0;
    logic          rd_valid;
    logic [15:0]   rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_pd_n;
    logic [15:0]   mem_dq_out;
    logic          mem_dq_oe;
    logic [15:0]   mem_dq_in;

    psram_ctrl #(.ADDR_W(AW), .PWRUP_CYC(PWR), .RUN_LIMIT(LIMIT)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_len(req_len), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_pd_n(mem_pd_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // memory model
    logic [15:0] mem     [256];
    logic [15:0] ref_mem [256];
    logic [1:0]  cur_be = 2'b11;
    int lane_bad = 0, cont_bad = 0, we_bad = 0;

    assign mem_dq_in = {(!mem_cs_n && !mem_oe_n && !mem_ub_n) ? mem[mem_addr][15:8] : 8'hEE,
                        (!mem_cs_n && !mem_oe_n && !mem_lb_n) ? mem[mem_addr][7:0]  : 8'hEE};

    always @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
            if (!mem_ub_n) mem[mem_addr][15:8] <= mem_dq_out[15:8];
            if (!mem_lb_n) mem[mem_addr][7:0]  <= mem_dq_out[7:0];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_cs_n) begin
                if (mem_lb_n != !cur_be[0] || mem_ub_n != !cur_be[1]) lane_bad++;
            end else if (!mem_ub_n || !mem_lb_n) lane_bad++;
            if (mem_dq_oe && !mem_oe_n) cont_bad++;
            if (!mem_we_n && mem_cs_n) we_bad++;
        end
    end

    function automatic logic [15:0] mask(input logic [15:0] w, input logic [1:0] be);
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic do_req(input bit wr, input int addr, input logic [1:0] be,
                          input int len, input logic [63:0] wdat, input string tag);
        int exp_off [4];
        int run = 0, off = 0, k = 0, n = 0, acc = 0;
        bit full;
        for (int i = 0; i <= len; i++) begin
            int a = (addr + i) % 256;
            int fl = wr ? WR_FUL : RD_FUL;
            if (i == 0) begin off += fl; run = fl; end
            else if (a % 4 == 0) begin off += PREC + fl; run = fl; end
            else if (run + PAGE <= LIMIT) begin off += PAGE; run += PAGE; end
            else begin off += fl; run = fl; end
            exp_off[i] = off;
        end
        full = 1'b0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(addr); req_be = be;
        req_len = 2'(len); req_wdata = wdat; cur_be = be;
        if (wr) begin
            for (int i = 0; i <= len; i++) begin
                int a = (addr + i) % 256;
                if (be[0]) ref_mem[a][7:0]  = wdat[16*i +: 8];
                if (be[1]) ref_mem[a][15:8] = wdat[16*i + 8 +: 8];
            end
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        acc = cyc;
        forever begin
            n = cyc - acc;
            if (rd_valid) begin
                if (wr || k > len) begin
                    check(1'b0, {tag, " R2 stray strobe"}, n, -1);
                end else begin
                    check(n == exp_off[k], {tag, " R2/R4/R5/R7 strobe cycle"}, n, exp_off[k]);
                    check(rd_data == mask(ref_mem[(addr + k) % 256], be), {tag, " R2/R3 data"},
                          int'(rd_data), int'(mask(ref_mem[(addr + k) % 256], be)));
                end
                k++;
            end
            if (req_ready) begin
                check(n == exp_off[len] + PREC, {tag, " R9 ready return"}, n, exp_off[len] + PREC);
                if (!wr) check(k == len + 1, {tag, " R2 beat count"}, k, len + 1);
                break;
            end
            if (n > 300) begin
                check(1'b0, {tag, " R9 timeout"}, n, exp_off[len]);
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        bit cs_ok;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) begin
            mem[i]     = {8'(i) ^ 8'h5A, 8'(i)};
            ref_mem[i] = {8'(i) ^ 8'h5A, 8'(i)};
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_cs_n && mem_pd_n && !req_ready && !rd_valid, "R1 reset state",
              {mem_cs_n, mem_pd_n, req_ready, rd_valid}, 4'b1100);
        rst = 1'b0;
        // R1: power-up hold
        cs_ok = 1'b1;
        repeat (PWR) begin
            @(posedge clk);
            @(negedge clk);
            if (!mem_cs_n || !mem_pd_n) cs_ok = 1'b0;
        end
        check(!req_ready, "R1 ready low at wait end", req_ready, 0);
        check(cs_ok, "R1 select held high", cs_ok, 1);
        @(posedge clk);
        @(negedge clk);
        check(req_ready, "R1 ready after wait", req_ready, 1);

        // directed
        do_req(1'b0, 8'h10, 2'b11, 0, '0, "single read R2");
        do_req(1'b0, 8'h20, 2'b11, 3, '0, "page read R4 R7");
        do_req(1'b0, 8'h32, 2'b11, 3, '0, "crossing read R5");
        do_req(1'b0, 8'h41, 2'b10, 1, '0, "upper lane read R3");
        do_req(1'b1, 8'h50, 2'b11, 3, 64'h4444_3333_2222_1111, "page write R6");
        do_req(1'b0, 8'h50, 2'b11, 3, '0, "write readback R6");
        do_req(1'b1, 8'h60, 2'b01, 0, 64'h0000_0000_0000_ABCD, "lower lane write R3");
        do_req(1'b1, 8'h61, 2'b10, 0, 64'h0000_0000_0000_9876, "upper lane write R3");
        do_req(1'b0, 8'h60, 2'b11, 1, '0, "lane readback R3");
        do_req(1'b1, 8'h7E, 2'b11, 3, 64'hDDDD_CCCC_BBBB_AAAA, "crossing write R5");
        do_req(1'b0, 8'h7E, 2'b11, 3, '0, "crossing readback R5");
        do_req(1'b0, 8'hFE, 2'b01, 3, '0, "address wrap R5");

        // random
        for (int i = 0; i < 60; i++) begin
            logic [1:0] be = 2'(1 + ($urandom % 3));
            do_req(1'($urandom % 2), int'($urandom % 256), be, int'($urandom % 4),
                   {$urandom, $urandom}, "random R2 R6");
        end

        check(lane_bad == 0, "R3 lane pins", lane_bad, 0);
        check(cont_bad == 0, "R8 bus contention", cont_bad, 0);
        check(we_bad == 0, "R6 write outside select", we_bad, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule